// File: doc/BRIEF.md
# Glitchable Clock Generator

This block derives an output clock from the system clock through a programmable divider. Outside a glitch burst the output follows a primary divisor. Each half-period of the output lasts (D + 1) system clocks, so the output frequency is F_sys / (2 * (D + 1)). With a 100 MHz system clock, D = 0 gives 50 MHz, D = 1 gives 25 MHz and D = 2 gives about 16.67 MHz.

A rising edge on the glitch trigger input starts a burst. During the burst the divider runs on a secondary divisor for a programmed number of output edges, and then it returns to the primary divisor by itself. The result is a short, deliberate stretch of output at another frequency, which is useful for fault-injection experiments.

Software sets the block up through a byte-wide register write port. The port has four write-only locations: a reserved settings byte, the primary divisor, the secondary divisor and the burst length.

Top module: `glitch_clkgen`

## Requirements
- R1: After reset the output clock is low, all registers hold zero, and the output toggles on every system clock (primary divisor 0).
- R2: Outside a burst, every output half-period lasts (A + 1) system clocks, where A is the value at write offset 1 (primary divisor).
- R3: A divisor written while the divider is running takes effect only at the next counter wrap. The half-period already in progress completes at its old length.
- R4: Writes to offset 0 (reserved settings byte) are accepted and change neither the divisors, the burst length nor the output timing.
- R5: The glitch input passes through a two-stage synchronizer and is detected on its rising edge. The divider counter restarts from zero on the third rising system clock edge after the input is first sampled high. From then on it counts with the secondary divisor B (offset 2), so the first burst edge comes (B + 1) clocks after the restart.
- R6: A burst contains exactly N = C + 1 output toggles, where C is the value at offset 3, captured when the burst starts. Consecutive burst toggles are (B + 1) clocks apart. After the last burst toggle, the divider counter restarts on divisor A.
- R7: A rising edge on the glitch input during an active burst is ignored. It neither restarts nor extends the burst.
- R8: The burst-length boundaries hold: C = 0 gives a single glitched edge, and C = 255 gives 256 glitched edges.
- R9: A glitch input that stays high after a burst ends does not start another burst. Only a fresh rising edge does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Register offset: 0 reserved, 1 primary divisor, 2 secondary divisor, 3 burst length |
| wr_data | input | DATA_W (8) | Register write data |
| glitch_in | input | 1 | Asynchronous burst trigger, active on its rising edge |
| clk_out | output | 1 | Divided clock output, driven from a flip-flop |

## Verification
The hardest situations to reach are the ones where a trigger edge arrives inside a running burst, and where a burst runs to its largest length. The bench reaches both by lining the trigger up with an observed output toggle, so that the restart cycle is known exactly. It then lowers and raises the glitch input again partway through a ten-edge burst. It also programs a burst of 256 edges at the smallest secondary divisor and measures every toggle interval until the output returns to the primary rate.

// File: rtl/gcg_pkg.sv
package gcg_pkg;
   // Register offsets on the write port; decode depends on them.
   typedef enum logic [1:0] {
      GCG_REG_RSVD  = 2'd0,
      GCG_REG_DIV_A = 2'd1,
      GCG_REG_DIV_B = 2'd2,
      GCG_REG_BURST = 2'd3
   } gcg_reg_e;
endpackage

// File: rtl/gcg_regs.sv
module gcg_regs
   import gcg_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DIV_W-1:0]  div_a,
   output logic [DIV_W-1:0]  div_b,
   output logic [CNT_W-1:0]  edge_lim
);
   localparam logic [ADDR_W-1:0] OFS_A = ADDR_W'(GCG_REG_DIV_A);
   localparam logic [ADDR_W-1:0] OFS_B = ADDR_W'(GCG_REG_DIV_B);
   localparam logic [ADDR_W-1:0] OFS_N = ADDR_W'(GCG_REG_BURST);

   if (DATA_W < DIV_W || DATA_W < CNT_W) begin : g_bad_width
      $error("gcg_regs: DATA_W must cover DIV_W and CNT_W");
   end

   logic hit_a, hit_b, hit_n;
   assign hit_a = wr_en && (wr_addr == OFS_A);
   assign hit_b = wr_en && (wr_addr == OFS_B);
   assign hit_n = wr_en && (wr_addr == OFS_N);

   // Offset 0 is reserved: no storage, writes are accepted and dropped.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_a    <= '0;
         div_b    <= '0;
         edge_lim <= '0;
      end else begin
         if (hit_a) div_a    <= wr_data[DIV_W-1:0];
         if (hit_b) div_b    <= wr_data[DIV_W-1:0];
         if (hit_n) edge_lim <= wr_data[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/gcg_trig_sync.sv
module gcg_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 0) begin : g_bad_stages
      $error("gcg_trig_sync: STAGES must not be negative");
   end

   logic synced;
   logic prev;

   if (STAGES == 0) begin : g_bypass
      assign synced = async_in;
   end else if (STAGES == 1) begin : g_single
      logic stage;
      always_ff @(posedge clk) begin
         if (!rst_n) stage <= 1'b0;
         else        stage <= async_in;
      end
      assign synced = stage;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], async_in};
      end
      assign synced = chain[STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= synced;
   end

   assign rise = synced & ~prev;
endmodule

// File: rtl/gcg_burst.sv
module gcg_burst #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_rise,
   input  logic             tick,
   input  logic [CNT_W-1:0] edge_lim,
   output logic             active,
   output logic             use_b_nxt,
   output logic             restart,
   output logic [CNT_W-1:0] edge_cnt,
   output logic [CNT_W-1:0] burst_len
);
   logic start;
   logic finish;

   assign start     = trig_rise & ~active;
   assign finish    = active & tick & (edge_cnt == burst_len);
   assign restart   = start | finish;
   assign use_b_nxt = start | (active & ~finish);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         edge_cnt  <= '0;
         burst_len <= '0;
      end else if (start) begin
         active    <= 1'b1;
         edge_cnt  <= '0;
         burst_len <= edge_lim;
      end else if (active && tick) begin
         if (finish) active   <= 1'b0;
         else        edge_cnt <= edge_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/gcg_divider.sv
module gcg_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_a,
   input  logic [DIV_W-1:0] div_b,
   input  logic             use_b_nxt,
   input  logic             restart,
   output logic             tick,
   output logic             clk_out,
   output logic [DIV_W-1:0] cnt,
   output logic [DIV_W-1:0] cur_div
);
   logic reload;

   assign tick   = (cnt == cur_div);
   assign reload = tick | restart;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         cur_div <= '0;
         clk_out <= 1'b0;
      end else begin
         if (reload) begin
            cnt     <= '0;
            cur_div <= use_b_nxt ? div_b : div_a;
         end else begin
            cnt <= cnt + 1'b1;
         end
         if (tick) clk_out <= ~clk_out;
      end
   end
endmodule

// File: rtl/glitch_clkgen.sv
module glitch_clkgen #(
   parameter int DIV_W       = 8,
   parameter int CNT_W       = 8,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              glitch_in,
   output logic              clk_out
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("glitch_clkgen: ADDR_W must reach four offsets");
   end
   if (DIV_W < 1 || CNT_W < 1) begin : g_bad_div
      $error("glitch_clkgen: DIV_W and CNT_W must be positive");
   end

   logic [DIV_W-1:0] div_a, div_b, cur_div, div_cnt;
   logic [CNT_W-1:0] edge_lim, edge_cnt, burst_len;
   logic             trig_rise, burst_active, use_b_nxt, restart, div_tick;

   gcg_regs #(
      .DIV_W(DIV_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .div_a(div_a), .div_b(div_b), .edge_lim(edge_lim)
   );

   gcg_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(glitch_in), .rise(trig_rise)
   );

   gcg_burst #(.CNT_W(CNT_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise), .tick(div_tick),
      .edge_lim(edge_lim), .active(burst_active), .use_b_nxt(use_b_nxt),
      .restart(restart), .edge_cnt(edge_cnt), .burst_len(burst_len)
   );

   gcg_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .div_a(div_a), .div_b(div_b),
      .use_b_nxt(use_b_nxt), .restart(restart), .tick(div_tick),
      .clk_out(clk_out), .cnt(div_cnt), .cur_div(cur_div)
   );
endmodule

// File: rtl/gcg_checker.sv
module gcg_checker #(
   parameter int DIV_W  = 8,
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              clk_out,
   input logic              tick,
   input logic              restart,
   input logic              trig_rise,
   input logic              burst_active,
   input logic [CNT_W-1:0]  edge_cnt,
   input logic [CNT_W-1:0]  burst_len,
   input logic [DIV_W-1:0]  cur_div,
   input logic [DIV_W-1:0]  div_cnt,
   input logic [DIV_W-1:0]  div_a,
   input logic [DIV_W-1:0]  div_b,
   input logic [CNT_W-1:0]  edge_lim
);
   // R1
   reset_low_chk: assert property (@(posedge clk) !rst_n |=> !clk_out);

   // R2
   toggle_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_out != $past(clk_out)) |-> (div_cnt == '0));

   // R3
   divisor_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_div != $past(cur_div)) |-> $past(tick || restart));

   // R4
   reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0) |=> ($stable(div_a) && $stable(div_b) && $stable(edge_lim)));

   // R5
   burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_active) |-> $past(trig_rise));

   // R6
   edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_active |-> (edge_cnt <= burst_len));

   // R7
   no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_active && trig_rise && !(tick && edge_cnt == burst_len)) |=> burst_active);
endmodule

bind glitch_clkgen gcg_checker #(
   .DIV_W(DIV_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .clk_out(clk_out), .tick(div_tick), .restart(restart),
   .trig_rise(trig_rise), .burst_active(burst_active), .edge_cnt(edge_cnt),
   .burst_len(burst_len), .cur_div(cur_div), .div_cnt(div_cnt),
   .div_a(div_a), .div_b(div_b), .edge_lim(edge_lim)
);

// File: tb/glitch_clkgen_bench.sv
`timescale 1ns/1ps
module glitch_clkgen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       glitch_in = 1'b0;
   logic       clk_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   glitch_clkgen u_glitch_clkgen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .glitch_in(glitch_in), .clk_out(clk_out)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Caller stands at a negedge; returns at the negedge where a toggle shows.
   task automatic next_toggle(output int n);
      logic prev;
      prev = clk_out;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (clk_out == prev && n < 2000);
   endtask

   // Caller stands at a negedge; one cycle passes.
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle();
      int n;
      next_toggle(n);
      next_toggle(n);
   endtask

   task automatic t_reset();
      int n;
      @(negedge clk);
      chk("R1 out low in reset", int'(clk_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      next_toggle(n);
      next_toggle(n);
      chk("R1 default half-period", n, 1);
      next_toggle(n);
      chk("R1 default half-period again", n, 1);
   endtask

   task automatic t_primary();
      int n;
      wr(2'd1, 8'd3);
      settle();
      next_toggle(n);
      chk("R2 half-period A=3", n, 4);
      next_toggle(n);
      chk("R2 half-period A=3 again", n, 4);
   endtask

   task automatic t_live_update();
      int n;
      wr(2'd1, 8'd7);
      settle();
      wr(2'd1, 8'd1);
      next_toggle(n);
      chk("R3 running half-period keeps old length", n + 1, 8);
      next_toggle(n);
      chk("R3 new divisor after wrap", n, 2);
      next_toggle(n);
      chk("R3 new divisor steady", n, 2);
   endtask

   task automatic t_reserved();
      int n;
      wr(2'd1, 8'd4);
      settle();
      wr(2'd0, 8'hFF);
      next_toggle(n);
      chk("R4 reserved write, current period", n + 1, 5);
      next_toggle(n);
      chk("R4 reserved write, next period", n, 5);
      wr(2'd0, 8'h00);
      next_toggle(n);
      chk("R4 reserved write zero", n + 1, 5);
   endtask

   task automatic t_burst();
      int n;
      wr(2'd1, 8'd5);
      wr(2'd2, 8'd1);
      wr(2'd3, 8'd3);
      settle();
      glitch_in = 1'b1;
      next_toggle(n);
      chk("R5 first glitched edge", n, 5);
      for (int i = 0; i < 3; i++) begin
         next_toggle(n);
         chk("R6 glitched interval", n, 2);
      end
      next_toggle(n);
      chk("R6 back to primary", n, 6);
      next_toggle(n);
      chk("R9 held trigger no rerun", n, 6);
      next_toggle(n);
      chk("R9 held trigger no rerun again", n, 6);
      glitch_in = 1'b0;
      settle();
   endtask

   task automatic t_count_zero();
      int n;
      wr(2'd1, 8'd4);
      wr(2'd2, 8'd2);
      wr(2'd3, 8'd0);
      settle();
      glitch_in = 1'b1;
      next_toggle(n);
      chk("R8 single glitched edge", n, 6);
      next_toggle(n);
      chk("R8 single edge then primary", n, 5);
      glitch_in = 1'b0;
      settle();
   endtask

   task automatic t_count_max();
      int n;
      int bad;
      wr(2'd1, 8'd3);
      wr(2'd2, 8'd0);
      wr(2'd3, 8'd255);
      settle();
      glitch_in = 1'b1;
      next_toggle(n);
      chk("R8 max burst first edge", n, 4);
      bad = 0;
      for (int i = 0; i < 255; i++) begin
         next_toggle(n);
         if (n != 1) bad++;
      end
      chk("R8 max burst 255 unit intervals", bad, 0);
      next_toggle(n);
      chk("R8 max burst then primary", n, 4);
      glitch_in = 1'b0;
      settle();
   endtask

   task automatic t_retrigger();
      int n;
      int bad;
      wr(2'd1, 8'd3);
      wr(2'd2, 8'd2);
      wr(2'd3, 8'd9);
      settle();
      glitch_in = 1'b1;
      next_toggle(n);
      chk("R7 first edge", n, 6);
      glitch_in = 1'b0;
      bad = 0;
      for (int i = 0; i < 9; i++) begin
         if (i == 3) glitch_in = 1'b1;
         next_toggle(n);
         if (n != 3) bad++;
      end
      chk("R7 burst length unchanged by retrigger", bad, 0);
      next_toggle(n);
      chk("R7 primary after burst", n, 4);
      next_toggle(n);
      chk("R7 primary steady", n, 4);
      glitch_in = 1'b0;
      settle();
   endtask

   initial begin
      t_reset();
      t_primary();
      t_live_update();
      t_reserved();
      t_burst();
      t_count_zero();
      t_count_max();
      t_retrigger();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule